// File: doc/BRIEF.md
# Palette and Beam Position Read Port

This block is the read side of a picture unit's register set. A host issues single-byte reads by pulsing a read enable with a two-bit selector. The selector picks one of four sources: the palette data port, the horizontal beam counter, the vertical beam counter, or a status byte. Palette colors are 15 bits wide and beam positions are 9 bits wide. Each of these values is therefore returned as two bytes in turn, and each source has its own byte toggle that says which half the next read returns.

The block keeps a bus-hold byte, which is the last byte it returned. Any bit that a source does not drive is filled from this byte. The bus-hold byte is also the read data output, so a result stays visible until the next read. A capture pulse takes a snapshot of both beam positions and raises a "counter captured" flag. A status read reports that flag, clears it, and resets both beam toggles, so the host can start the next capture read from a known state. The palette storage itself sits outside the block: the block drives the palette index and receives the color at that index.

Top module: `palBeamReadPort`

## Requirements
- R1: After reset, rdData is 0, rdValid is 0, palAddr is 0, all three toggles are at the low half, and the captured flag is clear.
- R2: A read accepted on a clock edge makes rdValid high for the following cycle and places the returned byte on rdData. rdData then holds that byte until the next read.
- R3: A read with selector 0 (palette) while the palette toggle is low returns palColor[7:0] for the current index.
- R4: A palette read with the toggle high returns {previous rdData[7], palColor[14:8]}. After this read the index increments, and it wraps from 255 to 0.
- R5: A palIdxWr pulse loads palIdxIn into the index and clears the palette toggle. If a high-half palette read falls in the same cycle, the load takes priority over the increment, but the read still returns its byte.
- R6: A read with selector 1 (horizontal) or 2 (vertical) while that counter's toggle is low returns bits 7:0 of its captured position.
- R7: A beam counter read with the toggle high returns {previous rdData[7:1], position bit 8}.
- R8: Every palette, horizontal or vertical read flips only the toggle of that source. The three toggles are independent of one another.
- R9: A read with selector 3 (status) returns bit7 = fieldIn, bit6 = captured flag, bit5 = previous rdData[5], bit4 = pal50Hz, and bits 3:0 = VERSION.
- R10: A status read resets both beam toggles and clears the captured flag. If latchPulse is high in the same cycle, the flag ends up set.
- R11: latchPulse captures hBeamIn and vBeamIn and sets the captured flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rdEn | input | 1 | Read strobe |
| rdSel | input | 2 | Source select: 0 palette, 1 horizontal, 2 vertical, 3 status |
| palIdxWr | input | 1 | Load palette index |
| palIdxIn | input | 8 | New palette index |
| palColor | input | 15 | Color at palAddr from external palette storage |
| palAddr | output | 8 | Current palette index |
| latchPulse | input | 1 | Capture beam positions |
| hBeamIn | input | 9 | Live horizontal position |
| vBeamIn | input | 9 | Live vertical position |
| fieldIn | input | 1 | Field indicator reported in status bit 7 |
| pal50Hz | input | 1 | 50 Hz mode indicator |
| rdData | output | 8 | Bus-hold byte, the last byte returned |
| rdValid | output | 1 | High the cycle after a read |

## Verification
The palette port is read in pairs that start at index 254, so the two increments cross the wrap. Among these reads is an index load that lands while the toggle is high, including one in the same cycle as a high-half read; this separates the load priority from the increment. Beam reads alternate between horizontal and vertical, which shows that the toggles are independent. Status reads placed between beam reads, and one status read coinciding with a capture pulse, show the toggle reset and the set-over-clear flag priority. Positions chosen so that bits 8 and 5 differ between bytes make the bus-hold filling visible.

// File: rtl/palBeamPkg.sv
package palBeamPkg;
  typedef enum logic [1:0] {
    SEL_PAL  = 2'd0,
    SEL_HPOS = 2'd1,
    SEL_VPOS = 2'd2,
    SEL_STAT = 2'd3
  } srcSel_e;

  // Strobes from control to datapath, one per kind of byte access
  typedef struct packed {
    logic palLo;
    logic palHi;
    logic hLo;
    logic hHi;
    logic vLo;
    logic vHi;
    logic stat;
    logic idxLoad;
  } rdStrobe_t;
endpackage

// File: rtl/palBeamCtrl.sv
module palBeamCtrl
  import palBeamPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      rdEn,
  input  logic [1:0] rdSel,
  input  logic      palIdxWr,
  output rdStrobe_t strobe,
  output logic      palTgl,
  output logic      hTgl,
  output logic      vTgl
);
  srcSel_e sel;
  assign sel = srcSel_e'(rdSel);

  always_comb begin
    strobe = '0;
    strobe.idxLoad = palIdxWr;
    if (rdEn) begin
      unique case (sel)
        SEL_PAL:  begin strobe.palLo = !palTgl; strobe.palHi = palTgl; end
        SEL_HPOS: begin strobe.hLo = !hTgl; strobe.hHi = hTgl; end
        SEL_VPOS: begin strobe.vLo = !vTgl; strobe.vHi = vTgl; end
        SEL_STAT: strobe.stat = 1'b1;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      palTgl <= 1'b0;
      hTgl   <= 1'b0;
      vTgl   <= 1'b0;
    end else begin
      if (palIdxWr) palTgl <= 1'b0;
      else if (strobe.palLo || strobe.palHi) palTgl <= !palTgl;
      if (strobe.stat) begin
        hTgl <= 1'b0;
        vTgl <= 1'b0;
      end else begin
        if (strobe.hLo || strobe.hHi) hTgl <= !hTgl;
        if (strobe.vLo || strobe.vHi) vTgl <= !vTgl;
      end
    end
  end
endmodule

// File: rtl/palBeamData.sv
module palBeamData
  import palBeamPkg::*;
#(
  parameter int IDX_W   = 8,
  parameter int COLOR_W = 15,
  parameter int POS_W   = 9,
  parameter logic [3:0] VERSION = 4'h3
) (
  input  logic               clk,
  input  logic               rstN,
  input  rdStrobe_t          strobe,
  input  logic               rdEn,
  input  logic [IDX_W-1:0]   palIdxIn,
  input  logic [COLOR_W-1:0] palColor,
  output logic [IDX_W-1:0]   palAddr,
  input  logic               latchPulse,
  input  logic [POS_W-1:0]   hBeamIn,
  input  logic [POS_W-1:0]   vBeamIn,
  input  logic               fieldIn,
  input  logic               pal50Hz,
  output logic [7:0]         rdData,
  output logic               rdValid,
  output logic               capFlag
);
  localparam int HI_W = COLOR_W - 8;

  logic [POS_W-1:0] hPos, vPos;
  logic [7:0] nextByte;
  logic [7:0] busHold;

  assign rdData = busHold;

  always_comb begin
    nextByte = busHold;
    if (strobe.palLo) nextByte = palColor[7:0];
    if (strobe.palHi) nextByte = {busHold[7], palColor[COLOR_W-1 -: HI_W]};
    if (strobe.hLo)   nextByte = hPos[7:0];
    if (strobe.hHi)   nextByte = {busHold[7:1], hPos[8]};
    if (strobe.vLo)   nextByte = vPos[7:0];
    if (strobe.vHi)   nextByte = {busHold[7:1], vPos[8]};
    if (strobe.stat)  nextByte = {fieldIn, capFlag, busHold[5], pal50Hz, VERSION};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busHold <= '0;
      rdValid <= 1'b0;
      palAddr <= '0;
      hPos    <= '0;
      vPos    <= '0;
      capFlag <= 1'b0;
    end else begin
      rdValid <= rdEn;
      if (rdEn) busHold <= nextByte;
      if (strobe.idxLoad) palAddr <= palIdxIn;
      else if (strobe.palHi) palAddr <= palAddr + 1'b1;
      if (latchPulse) begin
        hPos    <= hBeamIn;
        vPos    <= vBeamIn;
        capFlag <= 1'b1;
      end else if (strobe.stat) begin
        capFlag <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/palBeamReadPort.sv
module palBeamReadPort
  import palBeamPkg::*;
#(
  parameter logic [3:0] VERSION = 4'h3
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        rdEn,
  input  logic [1:0]  rdSel,
  input  logic        palIdxWr,
  input  logic [7:0]  palIdxIn,
  input  logic [14:0] palColor,
  output logic [7:0]  palAddr,
  input  logic        latchPulse,
  input  logic [8:0]  hBeamIn,
  input  logic [8:0]  vBeamIn,
  input  logic        fieldIn,
  input  logic        pal50Hz,
  output logic [7:0]  rdData,
  output logic        rdValid
);
  rdStrobe_t strobe;
  logic palTgl, hTgl, vTgl, capFlag;

  palBeamCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .rdEn(rdEn), .rdSel(rdSel), .palIdxWr(palIdxWr),
    .strobe(strobe), .palTgl(palTgl), .hTgl(hTgl), .vTgl(vTgl)
  );

  palBeamData #(.VERSION(VERSION)) u_data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .rdEn(rdEn),
    .palIdxIn(palIdxIn), .palColor(palColor), .palAddr(palAddr),
    .latchPulse(latchPulse), .hBeamIn(hBeamIn), .vBeamIn(vBeamIn),
    .fieldIn(fieldIn), .pal50Hz(pal50Hz), .rdData(rdData),
    .rdValid(rdValid), .capFlag(capFlag)
  );
endmodule

// File: rtl/palBeamReadPort_chk.sv
module palBeamReadPort_chk #(
  parameter logic [3:0] VERSION = 4'h3
) (
  input logic       clk,
  input logic       rstN,
  input logic       rdEn,
  input logic [1:0] rdSel,
  input logic       palIdxWr,
  input logic [7:0] palAddr,
  input logic       latchPulse,
  input logic       pal50Hz,
  input logic [7:0] rdData,
  input logic       rdValid,
  input logic       palTgl,
  input logic       hTgl,
  input logic       vTgl,
  input logic       capFlag
);
  p_valid_follows_r2: assert property (@(posedge clk) disable iff (!rstN)
    rdEn |=> rdValid);

  p_hold_when_idle_r2: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |=> $stable(rdData));

  p_pal_incr_r4: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && rdSel == 2'd0 && palTgl && !palIdxWr) |=> palAddr == $past(palAddr) + 8'd1);

  p_beam_fill_r7: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && ((rdSel == 2'd1 && hTgl) || (rdSel == 2'd2 && vTgl)))
      |=> rdData[7:1] == $past(rdData[7:1]));

  p_stat_low_r9: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && rdSel == 2'd3) |=> (rdData[3:0] == VERSION && rdData[4] == $past(pal50Hz)));

  p_stat_clear_r10: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && rdSel == 2'd3 && !latchPulse) |=> (!hTgl && !vTgl && !capFlag));

  p_capture_sets_r11: assert property (@(posedge clk) disable iff (!rstN)
    latchPulse |=> capFlag);
endmodule

bind palBeamReadPort palBeamReadPort_chk #(.VERSION(VERSION)) u_chk (
  .clk(clk), .rstN(rstN), .rdEn(rdEn), .rdSel(rdSel), .palIdxWr(palIdxWr),
  .palAddr(palAddr), .latchPulse(latchPulse), .pal50Hz(pal50Hz),
  .rdData(rdData), .rdValid(rdValid), .palTgl(palTgl), .hTgl(hTgl),
  .vTgl(vTgl), .capFlag(capFlag)
);

// File: tb/test_palBeamReadPort.sv
module test_palBeamReadPort;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rdEn = 1'b0;
  logic [1:0] rdSel = 2'd0;
  logic palIdxWr = 1'b0;
  logic [7:0] palIdxIn = 8'd0;
  logic [14:0] palColor;
  logic [7:0] palAddr;
  logic latchPulse = 1'b0;
  logic [8:0] hBeamIn = 9'd0;
  logic [8:0] vBeamIn = 9'd0;
  logic fieldIn = 1'b1;
  logic pal50Hz = 1'b1;
  logic [7:0] rdData;
  logic rdValid;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = !clk;

  function automatic logic [14:0] colorOf(input int i);
    colorOf = 15'((i * 263 + 32'h1234) & 32'h7fff);
  endfunction

  assign palColor = colorOf(int'(palAddr));

  palBeamReadPort i_palBeamReadPort (
    .clk(clk), .rstN(rstN), .rdEn(rdEn), .rdSel(rdSel), .palIdxWr(palIdxWr),
    .palIdxIn(palIdxIn), .palColor(palColor), .palAddr(palAddr),
    .latchPulse(latchPulse), .hBeamIn(hBeamIn), .vBeamIn(vBeamIn),
    .fieldIn(fieldIn), .pal50Hz(pal50Hz), .rdData(rdData), .rdValid(rdValid)
  );

  // Behavioural reference model
  int mIdx = 0, mH = 0, mV = 0, mLast = 0;
  bit mPalT = 0, mHT = 0, mVT = 0, mFlag = 0, mValid = 0;

  always @(posedge clk) begin
    int c;
    int b;
    if (!rstN) begin
      mIdx = 0; mH = 0; mV = 0; mLast = 0;
      mPalT = 0; mHT = 0; mVT = 0; mFlag = 0; mValid = 0;
    end else begin
      b = mLast;
      c = int'(colorOf(mIdx));
      if (rdEn) begin
        case (rdSel)
          2'd0: begin
            if (!mPalT) b = c % 256;
            else begin
              b = (mLast / 128) * 128 + c / 256;
              if (!palIdxWr) mIdx = (mIdx + 1) % 256;
            end
            mPalT = !mPalT;
          end
          2'd1: begin
            b = mHT ? (mLast / 2) * 2 + mH / 256 : mH % 256;
            mHT = !mHT;
          end
          2'd2: begin
            b = mVT ? (mLast / 2) * 2 + mV / 256 : mV % 256;
            mVT = !mVT;
          end
          default: begin
            b = 128 * int'(fieldIn) + 64 * int'(mFlag) + ((mLast / 32) % 2) * 32
                + 16 * int'(pal50Hz) + 3;
            mHT = 0; mVT = 0; mFlag = 0;
          end
        endcase
        mLast = b;
      end
      if (palIdxWr) begin mIdx = int'(palIdxIn); mPalT = 0; end
      if (latchPulse) begin mH = int'(hBeamIn); mV = int'(vBeamIn); mFlag = 1; end
      mValid = rdEn;
    end
  end

  always @(posedge clk) begin
    #1;
    if (rstN && !finished) begin
      total++;
      if (int'(rdData) != mLast || rdValid != mValid || int'(palAddr) != mIdx) begin
        bad++;
        $display("FAIL R2 model: rdData=%0h rdValid=%0d palAddr=%0d expected %0h %0d %0d",
                 rdData, rdValid, palAddr, mLast, mValid, mIdx);
      end
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] s, input int exp, input string tag);
    @(negedge clk);
    rdEn = 1'b1; rdSel = s;
    @(negedge clk);
    rdEn = 1'b0;
    check(tag, int'(rdData), exp);
  endtask

  task automatic setIdx(input int i);
    @(negedge clk);
    palIdxWr = 1'b1; palIdxIn = 8'(i);
    @(negedge clk);
    palIdxWr = 1'b0;
  endtask

  initial begin
    logic [14:0] c;
    repeat (3) @(negedge clk);
    // R1 reset state, still in reset
    check("R1 rdData", int'(rdData), 0);
    check("R1 rdValid", int'(rdValid), 0);
    check("R1 palAddr", int'(palAddr), 0);
    rstN = 1'b1;

    // R5 index load, R3 low half, R4 high half with wrap
    setIdx(254);
    check("R5 load", int'(palAddr), 254);
    c = colorOf(254);
    rd(2'd0, int'(c[7:0]), "R3 pal lo 254");
    rd(2'd0, {1'b0, c[14:8]}, "R4 pal hi 254");
    check("R4 incr", int'(palAddr), 255);
    c = colorOf(255);
    rd(2'd0, int'(c[7:0]), "R3 pal lo 255");
    rd(2'd0, {1'b0, c[14:8]}, "R4 pal hi 255");
    check("R4 wrap", int'(palAddr), 0);

    // R11 capture
    @(negedge clk);
    hBeamIn = 9'h1A5; vBeamIn = 9'h0F3; latchPulse = 1'b1;
    @(negedge clk);
    latchPulse = 1'b0; hBeamIn = 9'h0; vBeamIn = 9'h1FF;
    // R9 status with flag set, R10 flag cleared after read
    rd(2'd3, 8'hD3, "R9 status flag set");
    rd(2'd3, 8'h93, "R10 flag cleared");
    // R6 low bytes, R8 independent toggles, R7 high bytes
    rd(2'd1, 8'hA5, "R6 h lo");
    rd(2'd2, 8'hF3, "R8 v lo after h lo");
    rd(2'd1, 8'hF3, "R7 h hi");
    rd(2'd2, 8'hF2, "R7 v hi");
    rd(2'd1, 8'hA5, "R8 h lo again");
    // R2 hold with no read
    repeat (3) @(negedge clk);
    check("R2 hold", int'(rdData), 8'hA5);
    // R10 status resets beam toggles
    rd(2'd3, 8'hB3, "R9 status bit5 fill");
    rd(2'd1, 8'hA5, "R10 h toggle reset");
    // R10 capture in same cycle as status read
    @(negedge clk);
    rdEn = 1'b1; rdSel = 2'd3; latchPulse = 1'b1;
    @(negedge clk);
    rdEn = 1'b0; latchPulse = 1'b0;
    check("R10 same-cycle byte", int'(rdData), 8'hB3);
    rd(2'd3, 8'hF3, "R10 set wins");

    // R5 load clears toggle
    setIdx(10);
    c = colorOf(10);
    rd(2'd0, int'(c[7:0]), "R3 pal lo 10");
    setIdx(40);
    c = colorOf(40);
    rd(2'd0, int'(c[7:0]), "R5 toggle cleared");
    // R5 load wins over increment in same cycle
    @(negedge clk);
    rdEn = 1'b1; rdSel = 2'd0; palIdxWr = 1'b1; palIdxIn = 8'd20;
    @(negedge clk);
    rdEn = 1'b0; palIdxWr = 1'b0;
    check("R5 same-cycle byte", int'(rdData), {1'b0, c[14:8]});
    check("R5 load wins", int'(palAddr), 20);
    c = colorOf(20);
    rd(2'd0, int'(c[7:0]), "R5 lo after load");

    repeat (2) @(negedge clk);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++; bad++;
      $display("FAIL R2 watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule